// File: doc/BRIEF.md
# Segment Descriptor Presence Checker

This block checks each memory access against a small table of segment descriptors held in registers. A requester presents a descriptor index and an offset within the segment. The block looks up the chosen descriptor. A descriptor is either a direct entry or a copy entry. A direct entry carries a base address, a segment length and a residency flag. A copy entry names a master entry, and the access then uses that master's address, length and residency, so every copy shares one segment.

One cycle after the request, the block returns a response. If the segment is resident and the offset lies inside it, the response is a physical address. Otherwise it is one of three faults. A segment that is absent and has a non-zero address needs a load from backing storage, and the response carries that storage block address. A segment that is absent and has a zero address needs a new segment allocated, and the response carries the size to allocate. An offset past the end of a resident segment is a bounds fault. Supervisor logic rewrites descriptors through a single write port. The storage transfer, the allocation policy and the fault handler all sit outside this block.

Top module: `seg_check_top`

## Requirements
- R1: After reset the response valid is low and every descriptor is cleared: not resident, address zero, length zero, not a copy. A lookup of any entry then gives an allocate fault with size 0.
- R2: A lookup accepted at one clock edge produces exactly one response with rsp_valid high on the following edge. With no lookup, rsp_valid is low.
- R3: For a resident entry with offset < length, the response has code 0, rsp_fault low, rsp_size 0 and rsp_addr = (base + offset) modulo 2^24.
- R4: For a resident entry with offset >= length, the response has code 3 (bounds), with rsp_addr 0 and rsp_size 0.
- R5: For a non-resident entry with a non-zero address field, the response has code 1 (load), with rsp_addr set to the storage block address and rsp_size 0.
- R6: For a non-resident entry with a zero address field, the response has code 2 (allocate), with rsp_size set to the entry's length and rsp_addr 0.
- R7: A copy entry (copy flag set, 4-bit master index) is judged entirely by its master's address, length and residency, and its own address, length and residency are ignored.
- R8: A copy entry whose master is itself a copy entry, including a copy that points at itself, gives code 3 (bounds).
- R9: When a descriptor write and a lookup happen in the same cycle, the lookup sees the table as it was before the write, including through a copy's master. The written value is seen from the next cycle on.
- R10: rsp_fault is high on a valid response exactly when rsp_code is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_idx | input | 4 | Descriptor index to look up |
| req_off | input | 16 | Offset within the segment |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | 4 | Descriptor index to write |
| wr_addr | input | 24 | Base or storage block address |
| wr_len | input | 16 | Segment length |
| wr_present | input | 1 | Residency flag |
| wr_copy | input | 1 | Marks the entry as a copy |
| wr_master | input | 4 | Master index for a copy entry |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_fault | output | 1 | The response is a fault |
| rsp_code | output | 2 | 0 none, 1 load, 2 allocate, 3 bounds |
| rsp_addr | output | 24 | Physical address, or the storage block address on a load fault |
| rsp_size | output | 16 | Segment size to allocate on an allocate fault |

## Verification
The assertions check on every cycle the properties that need no table contents. These are the one-cycle request-to-response timing, the quiet output after reset, the agreement between the fault flag and the code, a zero size on successful responses, a zero address on allocate faults and a non-zero address on load faults. The values that depend on the table can only be shown by the bench's scenarios. These include address arithmetic with wrap-around, the bounds edge at offset equal to length, resolution through a master, rejection of chained copies, and the old-contents rule when a write and a lookup collide.

// File: rtl/seg_check_pkg.sv
package seg_check_pkg;
  typedef enum logic [1:0] {
    FC_NONE   = 2'd0,
    FC_LOAD   = 2'd1,
    FC_ALLOC  = 2'd2,
    FC_BOUNDS = 2'd3
  } fault_code_e;
endpackage

// File: rtl/seg_desc_table.sv
// Descriptor storage with one write port and two combinational read ports.
// The second read port serves the master lookup of a copy entry.
module seg_desc_table #(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic              wr_present,
  input  logic              wr_copy,
  input  logic [IDX_W-1:0]  wr_master,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LEN_W-1:0]  rd_len,
  output logic              rd_present,
  output logic              rd_copy,
  output logic [IDX_W-1:0]  rd_master,
  input  logic [IDX_W-1:0]  mrd_idx,
  output logic [ADDR_W-1:0] mrd_addr,
  output logic [LEN_W-1:0]  mrd_len,
  output logic              mrd_present,
  output logic              mrd_copy
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ADDR_W-1:0] addr_q    [DEPTH];
  logic [LEN_W-1:0]  len_q     [DEPTH];
  logic              present_q [DEPTH];
  logic              copy_q    [DEPTH];
  logic [IDX_W-1:0]  master_q  [DEPTH];

  // The reads below see the registers before this edge's write, which is the old-contents rule.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i]    <= '0;
        len_q[i]     <= '0;
        present_q[i] <= 1'b0;
        copy_q[i]    <= 1'b0;
        master_q[i]  <= '0;
      end
    end else if (wr_en) begin
      addr_q[wr_idx]    <= wr_addr;
      len_q[wr_idx]     <= wr_len;
      present_q[wr_idx] <= wr_present;
      copy_q[wr_idx]    <= wr_copy;
      master_q[wr_idx]  <= wr_master;
    end
  end

  always_comb begin
    rd_addr     = addr_q[rd_idx];
    rd_len      = len_q[rd_idx];
    rd_present  = present_q[rd_idx];
    rd_copy     = copy_q[rd_idx];
    rd_master   = master_q[rd_idx];
    mrd_addr    = addr_q[mrd_idx];
    mrd_len     = len_q[mrd_idx];
    mrd_present = present_q[mrd_idx];
    mrd_copy    = copy_q[mrd_idx];
  end
endmodule

// File: rtl/seg_resolve.sv
// Picks the effective descriptor: the entry itself, or its master for a copy entry.
module seg_resolve #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic [ADDR_W-1:0] ent_addr,
  input  logic [LEN_W-1:0]  ent_len,
  input  logic              ent_present,
  input  logic              ent_copy,
  input  logic [ADDR_W-1:0] mst_addr,
  input  logic [LEN_W-1:0]  mst_len,
  input  logic              mst_present,
  input  logic              mst_copy,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [LEN_W-1:0]  eff_len,
  output logic              eff_present,
  output logic              chain_err
);
  always_comb begin
    if (ent_copy) begin
      eff_addr    = mst_addr;
      eff_len     = mst_len;
      eff_present = mst_present;
      chain_err   = mst_copy;
    end else begin
      eff_addr    = ent_addr;
      eff_len     = ent_len;
      eff_present = ent_present;
      chain_err   = 1'b0;
    end
  end
endmodule

// File: rtl/seg_judge.sv
// Turns the effective descriptor and the offset into a fault decision and result fields.
module seg_judge
  import seg_check_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [LEN_W-1:0]  eff_len,
  input  logic              eff_present,
  input  logic              chain_err,
  input  logic [LEN_W-1:0]  offset,
  output fault_code_e       code,
  output logic              fault,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LEN_W-1:0]  out_size
);
  always_comb begin
    code     = FC_NONE;
    fault    = 1'b0;
    out_addr = '0;
    out_size = '0;
    if (chain_err) begin
      code  = FC_BOUNDS;
      fault = 1'b1;
    end else if (!eff_present) begin
      fault = 1'b1;
      if (eff_addr == '0) begin
        code     = FC_ALLOC;
        out_size = eff_len;
      end else begin
        code     = FC_LOAD;
        out_addr = eff_addr;
      end
    end else if (offset >= eff_len) begin
      code  = FC_BOUNDS;
      fault = 1'b1;
    end else begin
      out_addr = eff_addr + ADDR_W'(offset);
    end
  end
endmodule

// File: rtl/seg_check_top.sv
module seg_check_top
  import seg_check_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [LEN_W-1:0]  req_off,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic              wr_present,
  input  logic              wr_copy,
  input  logic [IDX_W-1:0]  wr_master,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [1:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [LEN_W-1:0]  rsp_size
);
  logic [ADDR_W-1:0] ent_addr, mst_addr, eff_addr, j_addr;
  logic [LEN_W-1:0]  ent_len, mst_len, eff_len, j_size;
  logic              ent_present, mst_present, eff_present;
  logic              ent_copy, mst_copy, chain_err, j_fault;
  logic [IDX_W-1:0]  ent_master;
  fault_code_e       j_code;

  seg_desc_table #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) table_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_len(wr_len),
    .wr_present(wr_present), .wr_copy(wr_copy), .wr_master(wr_master),
    .rd_idx(req_idx), .rd_addr(ent_addr), .rd_len(ent_len),
    .rd_present(ent_present), .rd_copy(ent_copy), .rd_master(ent_master),
    .mrd_idx(ent_master), .mrd_addr(mst_addr), .mrd_len(mst_len),
    .mrd_present(mst_present), .mrd_copy(mst_copy)
  );

  seg_resolve #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) resolve_i (
    .ent_addr(ent_addr), .ent_len(ent_len), .ent_present(ent_present), .ent_copy(ent_copy),
    .mst_addr(mst_addr), .mst_len(mst_len), .mst_present(mst_present), .mst_copy(mst_copy),
    .eff_addr(eff_addr), .eff_len(eff_len), .eff_present(eff_present), .chain_err(chain_err)
  );

  seg_judge #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) judge_i (
    .eff_addr(eff_addr), .eff_len(eff_len), .eff_present(eff_present),
    .chain_err(chain_err), .offset(req_off),
    .code(j_code), .fault(j_fault), .out_addr(j_addr), .out_size(j_size)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_code  <= 2'd0;
      rsp_addr  <= '0;
      rsp_size  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= j_fault;
        rsp_code  <= j_code;
        rsp_addr  <= j_addr;
        rsp_size  <= j_size;
      end
    end
  end
endmodule

// File: rtl/seg_check_sva.sv
module seg_check_sva #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [1:0]        rsp_code,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [LEN_W-1:0]  rsp_size
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid);
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r2_no_rsp_when_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r10_flag_matches_code: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault == (rsp_code != 2'd0)));
  a_r3_ok_has_no_size: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 2'd0) |-> (rsp_size == '0));
  a_r6_alloc_has_no_addr: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 2'd2) |-> (rsp_addr == '0));
  a_r5_load_addr_nonzero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 2'd1) |-> (rsp_addr != '0));
endmodule

bind seg_check_top seg_check_sva #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_addr(rsp_addr), .rsp_size(rsp_size)
);

// File: tb/seg_check_top_tb_top.sv
`timescale 1ns/1ps
module seg_check_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_idx = '0;
  logic [15:0] req_off = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [23:0] wr_addr = '0;
  logic [15:0] wr_len = '0;
  logic        wr_present = 1'b0;
  logic        wr_copy = 1'b0;
  logic [3:0]  wr_master = '0;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_code;
  logic [23:0] rsp_addr;
  logic [15:0] rsp_size;

  always #2 clk = ~clk;

  seg_check_top dut_i (.*);

  typedef struct {
    logic [1:0]  code;
    logic        fault;
    logic [23:0] addr;
    logic [15:0] size;
    int          due;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  logic [23:0] m_addr [16];
  logic [15:0] m_len  [16];
  logic        m_pres [16];
  logic        m_copy [16];
  logic [3:0]  m_mst  [16];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic exp_t predict(input logic [3:0] idx, input logic [15:0] off, input string tag);
    exp_t e;
    int j = idx;
    e.code = 2'd0; e.fault = 1'b0; e.addr = '0; e.size = '0; e.tag = tag; e.due = 0;
    if (m_copy[idx]) j = m_mst[idx];
    if (m_copy[idx] && m_copy[j]) begin
      e.code = 2'd3; e.fault = 1'b1;
    end else if (!m_pres[j]) begin
      e.fault = 1'b1;
      if (m_addr[j] == 24'd0) begin e.code = 2'd2; e.size = m_len[j]; end
      else begin e.code = 2'd1; e.addr = m_addr[j]; end
    end else if (off >= m_len[j]) begin
      e.code = 2'd3; e.fault = 1'b1;
    end else begin
      e.addr = m_addr[j] + {8'd0, off};
    end
    return e;
  endfunction

  // One cycle of stimulus: optional write and optional lookup, driven at the falling edge.
  task automatic step(input bit we, input logic [3:0] wi, input logic [23:0] wa, input logic [15:0] wl,
                      input bit wp, input bit wc, input logic [3:0] wm,
                      input bit rv, input logic [3:0] ri, input logic [15:0] ro, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_addr = wa; wr_len = wl;
    wr_present = wp; wr_copy = wc; wr_master = wm;
    req_valid = rv; req_idx = ri; req_off = ro;
    if (rv) begin
      e = predict(ri, ro, tag);
      e.due = cyc + 1;
      q.push_back(e);
    end
    if (we) begin
      m_addr[wi] = wa; m_len[wi] = wl; m_pres[wi] = wp; m_copy[wi] = wc; m_mst[wi] = wm;
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [23:0] a, input logic [15:0] l,
                    input bit p, input bit c, input logic [3:0] m);
    step(1, i, a, l, p, c, m, 0, 0, 0, "");
  endtask

  task automatic rd(input logic [3:0] i, input logic [15:0] o, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, i, o, tag);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  // Monitor: compares each response against the scoreboard head at its due cycle.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        n_tests++;
        if (!rsp_valid) begin
          n_fail++;
          $display("FAIL R2 (%s): rsp_valid=0 expected 1", e.tag);
        end else if (rsp_code !== e.code || rsp_fault !== e.fault ||
                     rsp_addr !== e.addr || rsp_size !== e.size) begin
          n_fail++;
          $display("FAIL %s: code=%0d fault=%0d addr=%h size=%h expected code=%0d fault=%0d addr=%h size=%h",
                   e.tag, rsp_code, rsp_fault, rsp_addr, rsp_size, e.code, e.fault, e.addr, e.size);
        end
      end else if (rsp_valid) begin
        n_tests++; n_fail++;
        $display("FAIL R2: unexpected rsp_valid=1 expected 0");
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_addr[i] = '0; m_len[i] = '0; m_pres[i] = 0; m_copy[i] = 0; m_mst[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (rsp_valid !== 1'b0) begin n_fail++; $display("FAIL R1: rsp_valid=%b expected 0", rsp_valid); end
    rst = 1'b0;
    rd(5, 0, "R1 cleared entry");
    rd(15, 16'h0044, "R1 cleared entry");
    wr(1, 24'h001000, 16'h0100, 1, 0, 0);
    wr(2, 24'h00ABCD, 16'd50, 0, 0, 0);
    wr(3, 24'h000000, 16'h0400, 0, 0, 0);
    wr(4, 24'h777777, 16'h0001, 0, 1, 1);
    wr(5, 24'h000000, 16'hFFFF, 1, 1, 4);
    wr(6, 24'h000000, 16'h0000, 0, 1, 6);
    wr(7, 24'hFFFFF0, 16'h0040, 1, 0, 0);
    wr(8, 24'h000000, 16'h0000, 0, 1, 2);
    wr(9, 24'h123456, 16'h0000, 0, 1, 3);
    rd(1, 16'h0020, "R3 in range");
    rd(1, 16'h00FF, "R3 last byte");
    rd(7, 16'h0020, "R3 address wrap");
    rd(1, 16'h0100, "R4 offset equals length");
    rd(1, 16'hFFFF, "R4 large offset");
    rd(2, 16'h0000, "R5 load fault");
    rd(3, 16'h0010, "R6 allocate fault");
    rd(4, 16'h0080, "R7 copy to resident");
    rd(8, 16'h0000, "R7 copy to absent");
    rd(9, 16'h0000, "R7 copy to allocate");
    rd(5, 16'h0000, "R8 copy of copy");
    rd(6, 16'h0000, "R8 self copy");
    idle();
    @(negedge clk);
    n_tests++;
    if (rsp_valid !== 1'b0) begin n_fail++; $display("FAIL R2: idle rsp_valid=%b expected 0", rsp_valid); end
    step(1, 1, 24'h200000, 16'h0010, 1, 0, 0, 1, 1, 16'h0020, "R9 old contents on collision");
    rd(1, 16'h0004, "R9 new contents next cycle");
    rd(1, 16'h0020, "R4 after rewrite");
    step(1, 1, 24'h000000, 16'h0300, 0, 0, 0, 1, 4, 16'h0008, "R9 old master through copy");
    rd(4, 16'h0008, "R9 new master through copy");
    step(1, 10, 24'h000ABC, 16'h0002, 0, 0, 0, 1, 10, 16'h0001, "R9 write and lookup cleared entry");
    rd(10, 16'h0001, "R5 after write");
    idle(); idle(); idle();
    n_tests++;
    if (q.size() != 0) begin n_fail++; $display("FAIL R2: %0d responses missing expected 0", q.size()); end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL R2: watchdog expired, run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule